// File: doc/BRIEF.md
# Periodic and One-Shot Event Comparator

This block is a single comparator channel of an event timer. It watches a shared 32-bit main counter and raises a one-cycle `fire` pulse whenever the counter reaches or steps over the programmed comparator value. The pulse goes to a separate interrupt block. Register decoding happens outside the block. Configuration arrives as level inputs for the mode and as a pulse that arms the value-set flag. Comparator writes arrive as data plus a bit mask.

In one-shot mode the comparator holds its value after a match. A value that the counter has already passed fires again only after the counter wraps. In periodic mode a comparator write normally lands in the period register. It reaches the comparator only when the value-set flag is armed. After each periodic match, a sequential divider works out how many whole periods the counter has already covered. The comparator is then moved past all of them in one update, so the next match always lies ahead of the counter. The channel reports `busy` until that rearm is complete.

A match that arrives while the divider is running is not signalled. It is remembered instead, and if the counter is switched off before anything else signals or clears it, the pulse is issued at the moment of switch-off.

Top module: `evt_cmp_channel`

## Requirements
- R1: After reset, `comp_out` is 0xFFFFFFFF, `period_out` is 0, and `valset_out`, `fire` and `busy` are 0.
- R2: A match occurs in a cycle where `cnt_en` and `cnt_tick` are both 1 and the comparator lies in the modular window (previous-cycle `cnt_val`, current `cnt_val`]. An accepted match gives `fire` = 1 in the next cycle only. `fire` is a single-cycle pulse, and no pulse occurs before the counter reaches the comparator.
- R3: A `cfg_valset_set` pulse arms the value-set flag (`valset_out` = 1). Any comparator write clears it, in either mode, and a write takes priority over a simultaneous arm.
- R4: With `cfg_periodic` = 0, a write merges into the comparator (bits where `wr_mask` is 1 take `wr_data`; the other bits keep their value), and `period_out` is forced to 0 from the next cycle on.
- R5: With `cfg_periodic` = 1, a write merges into the period register. The comparator takes the merged period value only if the value-set flag is armed; otherwise it is unchanged.
- R6: After an accepted match with a nonzero period in periodic mode, `busy` rises together with `fire` and stays high for 33 cycles. After that the comparator equals compval + (floor((counter − compval)/period) + 1)·period modulo 2^32, where counter is the `cnt_val` of the match cycle.
- R7: In one-shot mode, or with a zero period, the comparator is never changed by a match. A comparator value already behind the counter fires only after the counter wraps around to it.
- R8: While `busy` is 1, matches are not signalled, and the comparator changes only through a write. A write, or clearing `cfg_periodic`, aborts a running rearm and drops `busy` in the next cycle.
- R9: A match ignored because of `busy` is held pending. If `cnt_en` falls while a match is pending, `fire` pulses in the next cycle. A pending match is cleared by any fire or write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Main counter is running |
| cnt_tick | input | 1 | Main counter advanced this cycle |
| cnt_val | input | 32 | Current main counter value |
| cfg_periodic | input | 1 | 1 = periodic mode, 0 = one-shot mode |
| cfg_valset_set | input | 1 | Pulse arming the value-set flag |
| wr_en | input | 1 | Comparator write strobe |
| wr_data | input | 32 | Comparator write data |
| wr_mask | input | 32 | Per-bit write enable |
| fire | output | 1 | One-cycle match pulse |
| busy | output | 1 | Periodic rearm in progress |
| comp_out | output | 32 | Current comparator value |
| period_out | output | 32 | Current period value |
| valset_out | output | 1 | Value-set flag state |

## Verification
The assertions check the following on every cycle:
- `fire` is never two cycles long.
- `busy` only rises together with a fire.
- Any write clears the value-set flag.
- One-shot mode zeroes the period.
- The comparator stays frozen while idle in one-shot mode and while the divider runs.
- No match is signalled during `busy`.
- A pending match produces a pulse when the counter stops.

Only the bench scenarios can show that the arithmetic is right: the catch-up value after crossings of arbitrary size, the masked merges, the wrap-around behaviour of a stale one-shot value, and the exact rearm latency.

// File: rtl/evt_cmp_pkg.sv
package evt_cmp_pkg;
  localparam int unsigned EC_W = 32;
  typedef logic [EC_W-1:0] ec_word_t;

  // bits with mask set come from data, others keep old
  function automatic ec_word_t merge_bits(ec_word_t old_v, ec_word_t data, ec_word_t mask);
    return (old_v & ~mask) | (data & mask);
  endfunction

  // target lies in the modular window (last, now]
  function automatic logic crossed(ec_word_t last_v, ec_word_t now_v, ec_word_t target);
    ec_word_t d_step;
    ec_word_t d_tgt;
    d_step = now_v - last_v;
    d_tgt  = target - last_v;
    return (d_tgt != '0) && (d_tgt <= d_step);
  endfunction

  // comp + (q+1)*p == counter - rem + p, with rem = (counter-comp) mod p
  function automatic ec_word_t next_compare(ec_word_t counter, ec_word_t rem, ec_word_t per);
    return counter - rem + per;
  endfunction
endpackage

// File: rtl/evt_cmp_detect.sv
module evt_cmp_detect
  import evt_cmp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cnt_en,
  input  logic     cnt_tick,
  input  ec_word_t cnt_val,
  input  ec_word_t comp_val,
  output logic     hit,
  output logic     stop_evt
);
  ec_word_t last_q;
  logic     en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      en_q   <= 1'b0;
    end else begin
      last_q <= cnt_val;
      en_q   <= cnt_en;
    end
  end

  assign hit      = cnt_en && cnt_tick && crossed(last_q, cnt_val, comp_val);
  assign stop_evt = en_q && !cnt_en;
endmodule

// File: rtl/evt_cmp_divider.sv
module evt_cmp_divider #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         abort,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] remainder
);
  localparam int unsigned CW = $clog2(W + 1);

  logic          busy_q, done_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  num_q, rem_q, dvs_q;
  logic [W:0]    trial, rem_nx;

  always_comb begin
    trial  = {rem_q, num_q[W-1]};
    rem_nx = (trial >= {1'b0, dvs_q}) ? (trial - {1'b0, dvs_q}) : trial;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      num_q  <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
    end else if (abort) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      cnt_q  <= CW'(W);
      num_q  <= dividend;
      rem_q  <= '0;
      dvs_q  <= divisor;
    end else if (busy_q) begin
      num_q <= {num_q[W-2:0], 1'b0};
      rem_q <= rem_nx[W-1:0];
      cnt_q <= cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign remainder = rem_q;
endmodule

// File: rtl/evt_cmp_channel.sv
module evt_cmp_channel
  import evt_cmp_pkg::*;
#(
  parameter ec_word_t RESET_COMP = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cnt_en,
  input  logic            cnt_tick,
  input  logic [EC_W-1:0] cnt_val,
  input  logic            cfg_periodic,
  input  logic            cfg_valset_set,
  input  logic            wr_en,
  input  logic [EC_W-1:0] wr_data,
  input  logic [EC_W-1:0] wr_mask,
  output logic            fire,
  output logic            busy,
  output logic [EC_W-1:0] comp_out,
  output logic [EC_W-1:0] period_out,
  output logic            valset_out
);
  ec_word_t comp_q, period_q, base_q, dvsr_q, div_rem;
  logic     fire_q, valset_q, pend_q;
  logic     hit, stop_evt, div_busy, div_done;
  logic     busy_w, accept, blocked_hit, div_start, div_abort, stop_fire;
  ec_word_t merged_period, merged_comp;

  evt_cmp_detect u_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_en   (cnt_en),
    .cnt_tick (cnt_tick),
    .cnt_val  (cnt_val),
    .comp_val (comp_q),
    .hit      (hit),
    .stop_evt (stop_evt)
  );

  assign busy_w      = div_busy || div_done;
  assign accept      = hit && !busy_w;
  assign blocked_hit = hit && busy_w;
  assign stop_fire   = stop_evt && pend_q;
  assign div_start   = accept && cfg_periodic && (period_q != '0) && !wr_en;
  assign div_abort   = wr_en || !cfg_periodic;

  evt_cmp_divider #(.W(EC_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (div_start),
    .abort     (div_abort),
    .dividend  (cnt_val - comp_q),
    .divisor   (period_q),
    .busy      (div_busy),
    .done      (div_done),
    .remainder (div_rem)
  );

  assign merged_period = merge_bits(period_q, wr_data, wr_mask);
  assign merged_comp   = merge_bits(comp_q, wr_data, wr_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      comp_q   <= RESET_COMP;
      period_q <= '0;
      base_q   <= '0;
      dvsr_q   <= '0;
      fire_q   <= 1'b0;
      valset_q <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      fire_q <= accept || stop_fire;

      if (wr_en)               valset_q <= 1'b0;
      else if (cfg_valset_set) valset_q <= 1'b1;

      if (wr_en || accept || stop_fire) pend_q <= 1'b0;
      else if (blocked_hit)             pend_q <= 1'b1;

      if (!cfg_periodic) period_q <= '0;
      else if (wr_en)    period_q <= merged_period;

      if (wr_en) begin
        if (!cfg_periodic)  comp_q <= merged_comp;
        else if (valset_q)  comp_q <= merged_period;
      end else if (div_done) begin
        comp_q <= next_compare(base_q, div_rem, dvsr_q);
      end

      if (div_start) begin
        base_q <= cnt_val;
        dvsr_q <= period_q;
      end
    end
  end

  assign fire       = fire_q;
  assign busy       = busy_w;
  assign comp_out   = comp_q;
  assign period_out = period_q;
  assign valset_out = valset_q;
endmodule

// File: rtl/evt_cmp_channel_chk.sv
module evt_cmp_channel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_periodic,
  input logic        wr_en,
  input logic        fire,
  input logic        busy,
  input logic [31:0] comp_out,
  input logic [31:0] period_out,
  input logic        valset_out,
  input logic        div_busy,
  input logic        stop_evt,
  input logic        pending
);
  a_r2_fire_single: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);

  a_r3_valset_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !valset_out);

  a_r4_oneshot_no_period: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_periodic |=> (period_out == 32'd0));

  a_r6_busy_with_fire: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> fire);

  a_r7_oneshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wr_en && period_out == 32'd0) |=> $stable(comp_out));

  a_r8_frozen_while_dividing: assert property (@(posedge clk) disable iff (!rst_n)
    (div_busy && !wr_en) |=> $stable(comp_out));

  a_r8_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !stop_evt) |=> !fire);

  a_r9_stop_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && stop_evt) |=> fire);
endmodule

bind evt_cmp_channel evt_cmp_channel_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_periodic (cfg_periodic),
  .wr_en        (wr_en),
  .fire         (fire),
  .busy         (busy),
  .comp_out     (comp_out),
  .period_out   (period_out),
  .valset_out   (valset_out),
  .div_busy     (div_busy),
  .stop_evt     (stop_evt),
  .pending      (pend_q)
);

// File: tb/evt_cmp_channel_test.sv
module evt_cmp_channel_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b1;
  logic        cnt_tick = 1'b0;
  logic [31:0] cnt_val = '0;
  logic        cfg_periodic = 1'b0;
  logic        cfg_valset_set = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] wr_mask = '0;
  logic        fire, busy, valset_out;
  logic [31:0] comp_out, period_out;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  evt_cmp_channel uut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_tick(cnt_tick),
    .cnt_val(cnt_val), .cfg_periodic(cfg_periodic), .cfg_valset_set(cfg_valset_set),
    .wr_en(wr_en), .wr_data(wr_data), .wr_mask(wr_mask), .fire(fire), .busy(busy),
    .comp_out(comp_out), .period_out(period_out), .valset_out(valset_out)
  );

  function automatic logic [31:0] exp_next(logic [31:0] cv, logic [31:0] ctr, logic [31:0] per);
    logic [31:0] q;
    q = (ctr - cv) / per;
    return cv + (q + 32'd1) * per;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tick_by(logic [31:0] inc);
    cnt_tick = 1'b1;
    cnt_val  = cnt_val + inc;
    step();
    cnt_tick = 1'b0;
  endtask

  task automatic jump(logic [31:0] v);
    cnt_val = v;
    step();
  endtask

  task automatic write(logic [31:0] d, logic [31:0] m);
    wr_en = 1'b1; wr_data = d; wr_mask = m;
    step();
    wr_en = 1'b0;
  endtask

  task automatic arm_valset();
    cfg_valset_set = 1'b1;
    step();
    cfg_valset_set = 1'b0;
  endtask

  task automatic wait_idle(inout int bc);
    int guard;
    guard = 0;
    while (busy && guard < 200) begin
      step();
      if (busy) bc++;
      guard++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int bc;
    logic [31:0] c, p, a, b, ctr;
    void'($urandom(32'd20240611));
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    check("R1 comp", comp_out, 32'hFFFF_FFFF);
    check("R1 period", period_out, 32'd0);
    check("R1 valset", {31'd0, valset_out}, 32'd0);
    check("R1 fire", {31'd0, fire}, 32'd0);
    check("R1 busy", {31'd0, busy}, 32'd0);

    // R4 one-shot full write
    write(32'd100, 32'hFFFF_FFFF);
    check("R4 oneshot write", comp_out, 32'd100);
    jump(32'd95);
    for (int i = 0; i < 4; i++) begin
      tick_by(32'd1);
      check("R2 no early fire", {31'd0, fire}, 32'd0);
    end
    tick_by(32'd1);
    check("R2 fire on reach", {31'd0, fire}, 32'd1);
    step();
    check("R2 single pulse", {31'd0, fire}, 32'd0);
    check("R7 oneshot comp held", comp_out, 32'd100);

    // R4 masked merge
    write(32'hABCD_0000, 32'hFFFF_0000);
    check("R4 masked merge", comp_out, 32'hABCD_0064);

    // R7 stale value fires only after wrap
    write(32'd50, 32'hFFFF_FFFF);
    tick_by(32'd1000);
    check("R7 past value silent", {31'd0, fire}, 32'd0);
    jump(32'hFFFF_FFF0);
    tick_by(32'h42);
    check("R7 fires after wrap", {31'd0, fire}, 32'd1);

    // R5 periodic writes
    cfg_periodic = 1'b1;
    step();
    write(32'h40, 32'hFFFF_FFFF);
    check("R5 period loaded", period_out, 32'h40);
    check("R5 comp untouched", comp_out, 32'd50);
    write(32'h00AB_0000, 32'h00FF_0000);
    check("R5 period masked", period_out, 32'h00AB_0040);
    arm_valset();
    check("R3 valset armed", {31'd0, valset_out}, 32'd1);
    write(32'h1000, 32'hFFFF_FFFF);
    check("R5 comp via valset", comp_out, 32'h1000);
    check("R5 period", period_out, 32'h1000);
    check("R3 valset self clear", {31'd0, valset_out}, 32'd0);

    // R6 catch-up, R8 ignored match, R9 stop flush
    jump(32'h0F00);
    tick_by(32'h2345);
    check("R6 periodic fire", {31'd0, fire}, 32'd1);
    bc = busy ? 1 : 0;
    jump(32'h0FFF);
    if (busy) bc++;
    tick_by(32'd2);
    check("R8 match ignored while busy", {31'd0, fire}, 32'd0);
    if (busy) bc++;
    wait_idle(bc);
    check("R6 busy length", bc, 32'd33);
    check("R6 catch-up value", comp_out, exp_next(32'h1000, 32'h3245, 32'h1000));
    cnt_en = 1'b0;
    step();
    check("R9 fire on stop", {31'd0, fire}, 32'd1);
    cnt_en = 1'b1;
    step();
    check("R9 pulse ends", {31'd0, fire}, 32'd0);

    // R8 write aborts rearm
    jump(32'h3FFF);
    tick_by(32'd1);
    check("R8 fire before abort", {31'd0, fire}, 32'd1);
    write(32'h200, 32'hFFFF_FFFF);
    check("R8 abort drops busy", {31'd0, busy}, 32'd0);
    repeat (40) step();
    check("R8 comp after abort", comp_out, 32'h4000);
    check("R8 period after abort", period_out, 32'h200);

    // R4 switching to one-shot zeroes period; R3 clear in one-shot
    cfg_periodic = 1'b0;
    step();
    check("R4 period forced zero", period_out, 32'd0);
    arm_valset();
    write(32'h777, 32'hFFFF_FFFF);
    check("R3 valset cleared in oneshot", {31'd0, valset_out}, 32'd0);
    check("R4 oneshot comp", comp_out, 32'h777);

    // random periodic crossings (R6)
    for (int k = 0; k < 12; k++) begin
      cfg_periodic = 1'b1;
      c = $urandom;
      p = ($urandom & 32'h000F_FFFF) + 32'd1;
      a = ($urandom & 32'h3FF) + 32'd1;
      b = $urandom & 32'h00FF_FFFF;
      arm_valset();
      write(c, 32'hFFFF_FFFF);
      check("R5 rand comp", comp_out, c);
      write(p, 32'hFFFF_FFFF);
      check("R5 rand comp kept", comp_out, c);
      jump(c - a);
      tick_by(a + b);
      ctr = c + b;
      check("R2 rand fire", {31'd0, fire}, 32'd1);
      bc = 1;
      wait_idle(bc);
      check("R6 rand catch-up", comp_out, exp_next(c, ctr, p));
    end

    // random one-shot crossings (R7)
    for (int k = 0; k < 8; k++) begin
      cfg_periodic = 1'b0;
      c = $urandom;
      a = ($urandom & 32'hFFFF) + 32'd1;
      b = $urandom & 32'h0FFF_FFFF;
      write(c, 32'hFFFF_FFFF);
      jump(c - a);
      tick_by(a + b);
      check("R2 rand oneshot fire", {31'd0, fire}, 32'd1);
      step();
      check("R7 rand comp held", comp_out, c);
      check("R7 rand not busy", {31'd0, busy}, 32'd0);
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule